// File: doc/BRIEF.md
# Noise-Filtered Double-Buffered UART Receiver

This block turns an asynchronous serial line into bytes for a processor. Each bit is sampled sixteen times. Three of those samples, taken around the middle of the bit, go to a majority vote that decides the bit's value. A falling edge on the idle line only opens a frame if at least two of the three start-bit votes are low. A shorter disturbance sends the receiver back to idle without producing anything.

Incoming bits are assembled in a shift buffer. A completed frame moves into a separate holding register, and a one-cycle interrupt request announces it. Because of this second stage, the processor has one whole frame time to collect a byte before the next byte completes. If a frame completes while the holding register is still unread, that frame is dropped and a sticky overrun flag is set. Parity and stop-bit problems raise their own sticky flags. The byte is still delivered in those cases. One status-acknowledge strobe clears all three flags.

A small rate generator derives the sample tick from a base tick. It does this in two stages. First it picks a prescaler tap that divides the base tick by 1, 4, 16 or 64. Then it divides that tap by a programmable value between 2 and 16.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After a synchronous reset, rx_data is 0 and rx_full, rx_irq, err_overrun, err_parity and err_framing are all 0.
- R2: With base_tick high every cycle, sample_tick pulses once every T*D cycles. T is 1, 4, 16 or 64 for tap_sel 0, 1, 2 or 3. D is div_val for div_val 2 to 15, 16 for div_val 0, and 2 for div_val 1. Two sample ticks are never adjacent.
- R3: A frame is a low start bit, then 8 data bits LSB first, then a parity bit if parity_en is 1, then one stop bit. Each bit lasts 16 sample ticks. After the stop bit the byte appears on rx_data, rx_full goes to 1 and rx_irq pulses.
- R4: A start is accepted only when at least two of the three start-bit votes (sample counts 7, 8 and 9) are low. A low pulse shorter than the voting window produces no rx_irq and leaves rx_full unchanged. A valid frame that follows is received normally.
- R5: Every bit, including the start bit, is decided by a majority of its three votes. A disturbance that corrupts a single vote does not change the received byte or raise any error flag.
- R6: If rd_strobe arrives before the next frame's stop bit is decided, that next frame is loaded without an overrun.
- R7: A frame that completes while rx_full is 1 and no rd_strobe arrives in the same cycle is discarded. In that case rx_data keeps its old value, rx_irq does not pulse and err_overrun is set.
- R8: With parity_en at 1, parity_odd = 0 selects even parity, meaning the data ones plus the parity bit add up to an even count. parity_odd = 1 selects odd parity. A mismatch sets err_parity, and the byte is still loaded.
- R9: A stop bit whose majority vote is low sets err_framing, and the byte is still loaded.
- R10: The three error flags stay set until err_ack. err_ack clears all three on the next cycle. rd_strobe clears rx_full on the next cycle.
- R11: rx_irq is high for exactly one cycle per loaded frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Base prescaler enable pulse |
| tap_sel | input | 2 | Prescaler tap: /1, /4, /16, /64 |
| div_val | input | 4 | Tap divider, 2..15; 0 means 16, 1 means 2 |
| parity_en | input | 1 | Frame carries a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| rxd | input | 1 | Serial receive line, idle high |
| rd_strobe | input | 1 | Holding register read |
| err_ack | input | 1 | Clears all error flags |
| sample_tick | output | 1 | Oversampling tick (16 per bit) |
| rx_data | output | 8 | Holding register |
| rx_full | output | 1 | Holding register contains unread data |
| rx_irq | output | 1 | One-cycle receive interrupt request |
| err_overrun | output | 1 | Sticky overrun flag |
| err_parity | output | 1 | Sticky parity flag |
| err_framing | output | 1 | Sticky framing flag |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. rx_irq is a single-cycle pulse, and it is only raised when the holding register was empty or was being read. An overrun never disturbs rx_data. Sample ticks never touch. err_ack and rd_strobe clear their state unless a new frame lands in the same cycle.

Other behaviour depends on stimulus, so only the bench scenarios can show it. These cover the exact tick period for every tap and divider setting and the bytes recovered across a sweep of values and both parity senses. They also cover rejection of short start glitches, tolerance of single-vote disturbances inside bits, and the one-frame read margin compared with a true overrun.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic perr;
    logic ferr;
  } rx_err_t;

endpackage

// File: rtl/rxu_baud_gen.sv
module rxu_baud_gen #(
  parameter int TAP_COUNT     = 4,
  parameter int TAP_STEP_LOG2 = 2,
  parameter int DIV_W         = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         base_tick,
  input  logic [$clog2(TAP_COUNT)-1:0] tap_sel,
  input  logic [DIV_W-1:0]             div_val,
  output logic                         os_tick
);

  localparam int PRE_W   = TAP_STEP_LOG2 * (TAP_COUNT - 1);
  localparam int CNT_W   = DIV_W + 1;
  localparam int DIV_MAX = 2 ** DIV_W;

  logic [PRE_W-1:0]     pre_cnt;
  logic [TAP_COUNT-1:0] tap_hit;
  logic [CNT_W-1:0]     limit;
  logic [CNT_W-1:0]     div_cnt;

  // tap g fires once per 2^(g*step) base ticks
  generate
    for (genvar g = 0; g < TAP_COUNT; g++) begin : g_tap
      if (g == 0) begin : g_base
        assign tap_hit[g] = base_tick;
      end else begin : g_div
        assign tap_hit[g] = base_tick & (&pre_cnt[g*TAP_STEP_LOG2-1:0]);
      end
    end
  endgenerate

  always_comb begin
    if (div_val == '0)
      limit = CNT_W'(DIV_MAX);
    else if (div_val == DIV_W'(1))
      limit = CNT_W'(2);
    else
      limit = {1'b0, div_val};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      os_tick <= 1'b0;
    end else begin
      os_tick <= 1'b0;
      if (base_tick)
        pre_cnt <= pre_cnt + 1'b1;
      if (tap_hit[tap_sel]) begin
        if (div_cnt + 1'b1 >= limit) begin
          div_cnt <= '0;
          os_tick <= 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rxu_sync.sv
module rxu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst)
      chain <= '1;
    else
      chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/rxu_deser.sv
module rxu_deser
  import rxu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx,
  input  logic              parity_en,
  input  logic              parity_odd,
  output logic              done,
  output logic [DATA_W-1:0] data_o,
  output rx_err_t           err_o
);

  localparam int CNT_W  = $clog2(OSR);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] VOTE_A = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] VOTE_B = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] VOTE_C = CNT_W'(OSR / 2 + 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  os_cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic              s_a, s_b;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              vote_hi;

  // two of three votes decide the bit
  assign vote_hi = (s_a & s_b) | (s_a & rx) | (s_b & rx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      os_cnt  <= '0;
      bit_idx <= '0;
      s_a     <= 1'b1;
      s_b     <= 1'b1;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      data_o  <= '0;
      err_o   <= '0;
    end else begin
      done <= 1'b0;
      if (os_tick) begin
        if (state == ST_IDLE) begin
          if (!rx) begin
            state  <= ST_START;
            os_cnt <= CNT_W'(1);
          end
        end else begin
          os_cnt <= os_cnt + 1'b1;
          if (os_cnt == VOTE_A) s_a <= rx;
          if (os_cnt == VOTE_B) s_b <= rx;
          if (os_cnt == VOTE_C) begin
            case (state)
              ST_START: if (vote_hi) state <= ST_IDLE;
              ST_DATA:  shreg <= {vote_hi, shreg[DATA_W-1:1]};
              ST_PAR:   par_bit <= vote_hi;
              ST_STOP: begin
                done       <= 1'b1;
                data_o     <= shreg;
                err_o.ferr <= ~vote_hi;
                err_o.perr <= parity_en & ((^shreg) ^ par_bit ^ parity_odd);
                state      <= ST_IDLE;
              end
              default: ;
            endcase
          end
          if (os_cnt == LAST) begin
            case (state)
              ST_START: begin
                state   <= ST_DATA;
                bit_idx <= '0;
              end
              ST_DATA: begin
                if (bit_idx == IDX_LAST)
                  state <= parity_en ? ST_PAR : ST_STOP;
                else
                  bit_idx <= bit_idx + 1'b1;
              end
              ST_PAR:  state <= ST_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
  import rxu_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int OSR           = 16,
  parameter int TAP_COUNT     = 4,
  parameter int TAP_STEP_LOG2 = 2,
  parameter int DIV_W         = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         base_tick,
  input  logic [$clog2(TAP_COUNT)-1:0] tap_sel,
  input  logic [DIV_W-1:0]             div_val,
  input  logic                         parity_en,
  input  logic                         parity_odd,
  input  logic                         rxd,
  input  logic                         rd_strobe,
  input  logic                         err_ack,
  output logic                         sample_tick,
  output logic [DATA_W-1:0]            rx_data,
  output logic                         rx_full,
  output logic                         rx_irq,
  output logic                         err_overrun,
  output logic                         err_parity,
  output logic                         err_framing
);

  logic              rx_s;
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  rx_err_t           fr_err;

  rxu_baud_gen #(
    .TAP_COUNT    (TAP_COUNT),
    .TAP_STEP_LOG2(TAP_STEP_LOG2),
    .DIV_W        (DIV_W)
  ) baud_i (
    .clk      (clk),
    .rst      (rst),
    .base_tick(base_tick),
    .tap_sel  (tap_sel),
    .div_val  (div_val),
    .os_tick  (sample_tick)
  );

  rxu_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rx_s)
  );

  rxu_deser #(.DATA_W(DATA_W), .OSR(OSR)) deser_i (
    .clk       (clk),
    .rst       (rst),
    .os_tick   (sample_tick),
    .rx        (rx_s),
    .parity_en (parity_en),
    .parity_odd(parity_odd),
    .done      (fr_done),
    .data_o    (fr_data),
    .err_o     (fr_err)
  );

  // holding register stage: a read in the same cycle frees it for the new frame
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      rx_irq      <= 1'b0;
      err_overrun <= 1'b0;
      err_parity  <= 1'b0;
      err_framing <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (rd_strobe)
        rx_full <= 1'b0;
      if (err_ack) begin
        err_overrun <= 1'b0;
        err_parity  <= 1'b0;
        err_framing <= 1'b0;
      end
      if (fr_done) begin
        if (rx_full && !rd_strobe) begin
          err_overrun <= 1'b1;
        end else begin
          rx_data <= fr_data;
          rx_full <= 1'b1;
          rx_irq  <= 1'b1;
          if (fr_err.perr) err_parity  <= 1'b1;
          if (fr_err.ferr) err_framing <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_dbuf_chk.sv
module uart_rx_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_strobe,
  input logic              err_ack,
  input logic              sample_tick,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              rx_irq,
  input logic              err_overrun,
  input logic              err_parity,
  input logic              err_framing
);

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // R3
  irq_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> ($stable(rx_data) && !rx_irq));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (!$past(rx_full) || $past(rd_strobe)));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick);

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    err_ack |=> ((!err_parity && !err_framing) || rx_irq));

  // R10
  ack_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    err_ack |=> (!err_overrun || $past(rx_full)));

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> (!rx_full || rx_irq));

  // R10
  sticky_par_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_parity) |-> $past(err_ack));

  // R10
  sticky_frm_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_framing) |-> $past(err_ack));

endmodule

bind uart_rx_dbuf uart_rx_dbuf_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .rd_strobe  (rd_strobe),
  .err_ack    (err_ack),
  .sample_tick(sample_tick),
  .rx_data    (rx_data),
  .rx_full    (rx_full),
  .rx_irq     (rx_irq),
  .err_overrun(err_overrun),
  .err_parity (err_parity),
  .err_framing(err_framing)
);

// File: tb/uart_rx_dbuf_tb_top.sv
`timescale 1ns/1ps
module uart_rx_dbuf_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_tick = 1'b1;
  logic [1:0] tap_sel = 2'd0;
  logic [3:0] div_val = 4'd2;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_strobe = 1'b0;
  logic       err_ack = 1'b0;
  logic       sample_tick;
  logic [7:0] rx_data;
  logic       rx_full, rx_irq, err_overrun, err_parity, err_framing;

  int total = 0;
  int fails = 0;
  int irq_cnt = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  uart_rx_dbuf dut_i (
    .clk(clk), .rst(rst), .base_tick(base_tick), .tap_sel(tap_sel),
    .div_val(div_val), .parity_en(parity_en), .parity_odd(parity_odd),
    .rxd(rxd), .rd_strobe(rd_strobe), .err_ack(err_ack),
    .sample_tick(sample_tick), .rx_data(rx_data), .rx_full(rx_full),
    .rx_irq(rx_irq), .err_overrun(err_overrun), .err_parity(err_parity),
    .err_framing(err_framing)
  );

  always @(posedge clk) begin
    if (rst) irq_cnt <= 0;
    else if (rx_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input bit v, input bit gl);
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      rxd = (gl && (c == 15 || c == 16)) ? ~v : v;
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit pbit, input bit stopv, input bit gl);
    drive_bit(1'b0, gl);
    for (int i = 0; i < 8; i++) drive_bit(b[i], gl);
    if (parity_en) drive_bit(pbit, gl);
    drive_bit(stopv, gl);
    @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); err_ack = 1'b1;
    @(negedge clk); err_ack = 1'b0;
  endtask

  task automatic measure(input int t, input int d);
    int per, lim, n;
    per = (4 ** t) * ((d == 0) ? 16 : ((d < 2) ? 2 : d));
    @(negedge clk);
    tap_sel = 2'(t);
    div_val = 4'(d);
    lim = 0;
    @(negedge clk);
    while (!sample_tick && lim < 3000) begin @(negedge clk); lim++; end
    for (int k = 0; k < 2; k++) begin
      n = 0;
      @(negedge clk); n++;
      while (!sample_tick && n < 3000) begin @(negedge clk); n++; end
      chk(n == per, $sformatf("R2 tick period tap=%0d div=%0d", t, d), n, per);
    end
  endtask

  function automatic bit good_par(input logic [7:0] b, input bit odd);
    return (^b) ^ odd;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
    chk({rx_full, rx_irq, err_overrun, err_parity, err_framing} == 5'b0,
        "R1 flags", {rx_full, rx_irq, err_overrun, err_parity, err_framing}, 0);

    // R2 rate generator sweep
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 16; d++)
        measure(t, d);
    @(negedge clk);
    tap_sel = 2'd0;
    div_val = 4'd2;
    repeat (20) @(negedge clk);

    // R3 R8 byte sweep with parity, alternating sense
    parity_en = 1'b1;
    for (int v = 0; v < 256; v += 5) begin
      parity_odd = ((v / 5) % 2) == 1;
      base = irq_cnt;
      send_frame(8'(v), good_par(8'(v), parity_odd), 1'b1, 1'b0);
      chk(rx_data == 8'(v), "R3 byte value", rx_data, v);
      chk(rx_full && irq_cnt == base + 1, "R11 single irq", irq_cnt - base, 1);
      chk(!err_parity && !err_framing, "R8 no parity error", err_parity, 0);
      pulse_rd();
      chk(!rx_full, "R10 read clears full", rx_full, 0);
    end

    // R3 frames without parity
    parity_en = 1'b0;
    send_frame(8'h3C, 1'b0, 1'b1, 1'b0);
    chk(rx_data == 8'h3C && rx_full, "R3 no-parity byte", rx_data, 8'h3C);
    pulse_rd();
    send_frame(8'hC3, 1'b0, 1'b1, 1'b0);
    chk(rx_data == 8'hC3 && rx_full, "R3 no-parity byte", rx_data, 8'hC3);
    pulse_rd();

    // R5 single-vote disturbances in every bit
    parity_en = 1'b1;
    parity_odd = 1'b1;
    send_frame(8'h96, good_par(8'h96, 1'b1), 1'b1, 1'b1);
    chk(rx_data == 8'h96 && rx_full, "R5 glitched frame", rx_data, 8'h96);
    chk(!err_parity && !err_framing, "R5 no flags", {err_parity, err_framing}, 0);
    pulse_rd();

    // R4 short start glitch rejected
    base = irq_cnt;
    @(negedge clk); rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    chk(irq_cnt == base && !rx_full, "R4 glitch ignored", irq_cnt - base, 0);
    send_frame(8'h69, good_par(8'h69, 1'b1), 1'b1, 1'b0);
    chk(rx_data == 8'h69 && irq_cnt == base + 1, "R4 frame after glitch", rx_data, 8'h69);
    pulse_rd();

    // R8 wrong parity
    parity_odd = 1'b0;
    send_frame(8'h55, ~good_par(8'h55, 1'b0), 1'b1, 1'b0);
    chk(err_parity, "R8 parity flag", err_parity, 1);
    chk(rx_data == 8'h55 && rx_full, "R8 byte still loaded", rx_data, 8'h55);
    pulse_rd();
    repeat (3) @(negedge clk);
    chk(err_parity, "R10 parity sticky", err_parity, 1);
    pulse_ack();
    chk(!err_parity, "R10 ack clears parity", err_parity, 0);

    // R9 framing error
    parity_en = 1'b0;
    send_frame(8'hA7, 1'b0, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    chk(err_framing, "R9 framing flag", err_framing, 1);
    chk(rx_data == 8'hA7 && rx_full, "R9 byte still loaded", rx_data, 8'hA7);
    pulse_rd();
    pulse_ack();
    chk(!err_framing, "R10 ack clears framing", err_framing, 0);

    // R7 overrun
    base = irq_cnt;
    send_frame(8'h11, 1'b0, 1'b1, 1'b0);
    send_frame(8'h22, 1'b0, 1'b1, 1'b0);
    chk(rx_data == 8'h11, "R7 old data kept", rx_data, 8'h11);
    chk(err_overrun, "R7 overrun flag", err_overrun, 1);
    chk(irq_cnt == base + 1, "R7 no irq for dropped frame", irq_cnt - base, 1);
    pulse_rd();
    chk(!rx_full, "R10 read clears full", rx_full, 0);
    pulse_ack();
    chk(!err_overrun, "R10 ack clears overrun", err_overrun, 0);

    // R6 one frame of read margin
    base = irq_cnt;
    send_frame(8'h33, 1'b0, 1'b1, 1'b0);
    fork
      send_frame(8'h44, 1'b0, 1'b1, 1'b0);
      begin
        repeat (200) @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
      end
    join
    chk(rx_data == 8'h44 && rx_full, "R6 next frame loaded", rx_data, 8'h44);
    chk(!err_overrun, "R6 no overrun", err_overrun, 0);
    chk(irq_cnt == base + 2, "R6 two irqs", irq_cnt - base, 2);
    pulse_rd();

    done_flag = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule